// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a 1 KB data cache placed between a processor load/store port and a slower lower-level memory. Storage is organised as 32 lines of 32 bytes. Each line carries a valid flag and an address tag. A load that finds its line resident is answered in the same cycle it is presented. A load that misses holds the processor with a wait signal while the whole line is fetched as a burst of eight words. Once the burst ends, the load completes as a hit.

Stores never wait for memory. Each store goes into a four-entry posting queue, and that queue drains to memory on its own. A store that hits a resident line also updates that line. A store that misses does not bring the line in. The processor is held on a store only when the queue is full. Before any line fetch begins, the queue is drained completely, so a load can never see data older than a store that is still queued.

The processor side uses whole 32-bit words. It holds its request, address and write data stable for as long as the wait signal is high. The memory side is a single request/acknowledge port. Each acknowledge completes one word: either one queued store, or one beat of a line fetch.

Top module: `wt_dcache`

## Requirements
- R1: Address bits 4:2 pick the word within a line, bits 9:5 pick one of 32 lines, and bits 31:10 are the tag. Two addresses with the same line bits but different tags evict each other.
- R2: While reset is low and just after it, every line is invalid, `cpu_wait` is 0 when idle and `mem_req` is 0. The first load to any line therefore misses.
- R3: A load whose line is valid with a matching tag completes with `cpu_wait` at 0 in the cycle it is presented, returning the stored word on `cpu_rdata`.
- R4: A load miss holds `cpu_wait` at 1 while eight reads (`mem_we`=0) are issued. These go to the line base address, then ascending by 4 bytes, one word per `mem_ack`. The load then returns the fetched word.
- R5: Every accepted store reaches memory as exactly one `mem_we`=1 transaction, in issue order, with its word address and data. Request, address, direction and data stay stable until `mem_ack`. A store hit also updates the resident word.
- R6: A store that misses leaves the line state unchanged, so a later load of that address still misses.
- R7: The posting queue holds 4 stores. With memory not acknowledging, four stores complete without waiting, and a fifth is held by `cpu_wait` until an entry leaves.
- R8: No line-fetch read is issued to memory while any store is still queued.
- R9: Every load returns the value of the most recent store to that address, or the memory contents if there was none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held while `cpu_wait` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word (bits 1:0 ignored) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load has `cpu_wait` at 0 |
| cpu_wait | output | 1 | Processor stall; the access completes at an edge where it is 0 |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write of a queued store, 0 = line fetch beat |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data for store transactions |
| mem_ack | input | 1 | One-cycle completion of the current word |
| mem_rdata | input | 32 | Fetched word, valid with `mem_ack` on a read |

## Verification
The properties assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` unchanged while `cpu_wait` is high. They also assume that memory raises `mem_ack` for at most one cycle per word, and only while `mem_req` is high. The bench drives the processor port only through a task that holds every field until the wait signal drops. Its memory model acknowledges with random delays, never on two cycles in a row, and it can be stalled on purpose to fill the posting queue. Random addresses are drawn from three tags, four lines and eight words, so conflict evictions, store misses and reads of queued data occur often.

// File: rtl/wt_dcache_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the write-through data cache.
// Assumes: nothing beyond IEEE 1800-2017.
package wt_dcache_pkg;

    // Controller state: serving accesses, or fetching a missed line
    typedef enum logic {
        CS_RUN  = 1'b0,
        CS_FILL = 1'b1
    } cache_st_t;

endpackage

// File: rtl/wt_tag_store.sv
`timescale 1ns/1ps
// Module: per-line valid flag and tag, with a single-cycle hit compare.
// Assumes: the lookup index and tag are stable during a line fetch; the
// valid flags are the only state cleared by reset.
module wt_tag_store #(
    parameter int IDX_W     = 5,
    parameter int TAG_W     = 22,
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     look_idx,
    input  logic [TAG_W-1:0]     look_tag,
    output logic                 hit,
    input  logic                 mark_en,
    input  logic [IDX_W-1:0]     mark_idx,
    input  logic [TAG_W-1:0]     mark_tag,
    output logic [NUM_LINES-1:0] valid_vec
);

    logic [TAG_W-1:0] tag_q [NUM_LINES];

    // Valid flags: cleared by reset, set when a fetch completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_vec <= '0;
        else if (mark_en)
            valid_vec[mark_idx] <= 1'b1;
    end

    // Tag array: written with the tag of a freshly fetched line
    always_ff @(posedge clk) begin
        if (mark_en)
            tag_q[mark_idx] <= mark_tag;
    end

    // Hit decision: resident and same tag
    always_comb begin
        hit = valid_vec[look_idx] && (tag_q[look_idx] == look_tag);
    end

endmodule

// File: rtl/wt_data_store.sv
`timescale 1ns/1ps
// Module: line data array, one synchronous write port, asynchronous read.
// Assumes: the caller never writes and fetches into the same cycle from two
// sources; the mux in front of the write port is outside this module.
module wt_data_store #(
    parameter int IDX_W  = 5,
    parameter int BEAT_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IDX_W+BEAT_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [IDX_W+BEAT_W-1:0]  rd_slot,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int SLOTS = 1 << (IDX_W + BEAT_W);

    logic [DATA_W-1:0] word_q [SLOTS];

    // Word write from a store hit or a fetch beat
    always_ff @(posedge clk) begin
        if (wr_en)
            word_q[wr_slot] <= wr_data;
    end

    // Combinational read for the same-cycle hit path
    always_comb begin
        rd_data = word_q[rd_slot];
    end

endmodule

// File: rtl/wt_post_fifo.sv
`timescale 1ns/1ps
// Module: store posting queue (address + data), first in first out.
// Assumes: push is never raised when full and pop never when empty.
module wt_post_fifo #(
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [AW-1:0]              head_addr,
    output logic [DW-1:0]              head_data,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Status and head view
    always_comb begin
        empty     = (count == '0);
        full      = (count == CNT_W'(DEPTH));
        head_addr = addr_q[rd_ptr];
        head_data = data_q[rd_ptr];
    end

endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
// Module: direct-mapped write-through data cache controller (top).
// Assumes: the processor holds its request fields while cpu_wait is high;
// memory acknowledges one word per mem_ack and only while mem_req is high.
module wt_dcache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 32,
    parameter int WBUF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_wait,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import wt_dcache_pkg::*;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BEAT_W = OFF_W - BYTE_W;
    localparam int WORDS  = 1 << BEAT_W;
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WA_W   = ADDR_W - BYTE_W;
    localparam int CNT_W  = $clog2(WBUF_DEPTH + 1);

    cache_st_t         st;
    logic [BEAT_W-1:0] beat;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic [BEAT_W-1:0] a_word;
    logic              hit, filling, fill_go, fill_ack, fill_last;
    logic              wr_accept, pop;
    logic              wb_empty, wb_full;
    logic [CNT_W-1:0]  wb_count;
    logic [WA_W-1:0]   head_waddr;
    logic [DATA_W-1:0] head_data;
    logic [NUM_LINES-1:0] valid_vec;
    logic              ds_we;
    logic [IDX_W+BEAT_W-1:0] ds_wslot;
    logic [DATA_W-1:0] ds_wdata;
    logic              unused_low_addr;

    // Address split
    always_comb begin
        a_word = cpu_addr[OFF_W-1:BYTE_W];
        a_idx  = cpu_addr[OFF_W+IDX_W-1:OFF_W];
        a_tag  = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
        unused_low_addr = ^cpu_addr[BYTE_W-1:0];
    end

    // Control decode: stall, store acceptance, memory port ownership
    always_comb begin
        filling   = (st == CS_FILL);
        fill_go   = filling && wb_empty;
        fill_ack  = fill_go && mem_ack;
        fill_last = fill_ack && (beat == BEAT_W'(WORDS - 1));
        wr_accept = cpu_req && cpu_we && !wb_full && !filling;
        pop       = !fill_go && !wb_empty && mem_ack;
        cpu_wait  = filling || (cpu_req && (cpu_we ? wb_full : !hit));
        mem_req   = fill_go || !wb_empty;
        mem_we    = !fill_go;
        mem_addr  = fill_go ? {a_tag, a_idx, beat, {BYTE_W{1'b0}}}
                            : {head_waddr, {BYTE_W{1'b0}}};
        mem_wdata = head_data;
    end

    // Refill sequencer: start on a load miss, count beats, finish on the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= CS_RUN;
            beat <= '0;
        end else if (!filling) begin
            beat <= '0;
            if (cpu_req && !cpu_we && !hit)
                st <= CS_FILL;
        end else if (fill_ack) begin
            beat <= beat + 1'b1;
            if (fill_last)
                st <= CS_RUN;
        end
    end

    // Data array write source: fetch beat or store hit
    always_comb begin
        ds_we    = fill_ack || (wr_accept && hit);
        ds_wslot = {a_idx, fill_ack ? beat : a_word};
        ds_wdata = fill_ack ? mem_rdata : cpu_wdata;
    end

    wt_tag_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .NUM_LINES(NUM_LINES)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_idx(a_idx), .look_tag(a_tag), .hit(hit),
        .mark_en(fill_last), .mark_idx(a_idx), .mark_tag(a_tag),
        .valid_vec(valid_vec)
    );

    wt_data_store #(
        .IDX_W(IDX_W), .BEAT_W(BEAT_W), .DATA_W(DATA_W)
    ) u_data (
        .clk(clk), .wr_en(ds_we), .wr_slot(ds_wslot), .wr_data(ds_wdata),
        .rd_slot({a_idx, a_word}), .rd_data(cpu_rdata)
    );

    wt_post_fifo #(
        .AW(WA_W), .DW(DATA_W), .DEPTH(WBUF_DEPTH)
    ) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(wr_accept), .push_addr(cpu_addr[ADDR_W-1:BYTE_W]),
        .push_data(cpu_wdata), .pop(pop),
        .head_addr(head_waddr), .head_data(head_data),
        .empty(wb_empty), .full(wb_full), .count(wb_count)
    );

endmodule

// File: rtl/wt_dcache_chk.sv
`timescale 1ns/1ps
// Module: property checker for wt_dcache, attached by bind below.
// Assumes: inputs obey the handshakes stated in the brief.
module wt_dcache_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_LINES  = 32,
    parameter int WBUF_DEPTH = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cpu_req,
    input logic                            cpu_we,
    input logic                            cpu_wait,
    input logic                            mem_req,
    input logic                            mem_we,
    input logic                            mem_ack,
    input logic [ADDR_W-1:0]               mem_addr,
    input logic [DATA_W-1:0]               mem_wdata,
    input logic                            hit,
    input logic                            filling,
    input logic [$clog2(WBUF_DEPTH+1)-1:0] wb_count,
    input logic [NUM_LINES-1:0]            valid_vec
);
    localparam int CNT_W = $clog2(WBUF_DEPTH + 1);

    AST_RESET_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0 && !mem_req)); // R2
    AST_HIT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && hit && !filling) |-> !cpu_wait); // R3
    AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> cpu_wait); // R4
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)); // R5
    AST_WR_MISS_NOALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_wait && !hit) |=> $stable(valid_vec)); // R6
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && wb_count == CNT_W'(WBUF_DEPTH)) |-> cpu_wait); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= CNT_W'(WBUF_DEPTH)); // R7
    AST_FETCH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (wb_count == '0)); // R8

endmodule

bind wt_dcache wt_dcache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .WBUF_DEPTH(WBUF_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_wait(cpu_wait), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .hit(hit), .filling(filling), .wb_count(wb_count), .valid_vec(valid_vec)
);

// File: tb/tb_wt_dcache.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic against a
// reference memory image kept in the bench.
module tb_wt_dcache;

    logic        clk, rst_n;
    logic        cpu_req, cpu_we, cpu_wait;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0;
    bit mem_stall = 0;
    int wr_issued = 0, wr_seen = 0, rd_beat = 0;
    logic [31:0] fill_base;
    logic [31:0] bmem    [logic [31:0]];
    logic [31:0] ref_mem [logic [31:0]];
    logic [63:0] exp_q   [$];

    wt_dcache dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_wait(cpu_wait), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    function automatic logic [31:0] def_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : def_word(a);
    endfunction

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : def_word(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: decides at the falling edge, ack lasts one cycle
    initial begin
        mem_ack = 0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0;
            end else if (mem_req && !mem_stall && ($urandom % 4 != 0)) begin
                if (mem_we) begin
                    logic [63:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hX;
                    chk(mem_addr == e[63:32], "R5 store order addr", mem_addr, e[63:32]);
                    chk(mem_wdata == e[31:0], "R5 store data", mem_wdata, e[31:0]);
                    bmem[mem_addr] = mem_wdata;
                    wr_seen++;
                end else begin
                    if (rd_beat == 0) begin
                        fill_base = mem_addr;
                        chk(wr_seen == wr_issued, "R8 fetch after drain", wr_seen, wr_issued);
                        chk(mem_addr[4:0] == 5'd0, "R4 fetch starts at line base", mem_addr, {mem_addr[31:5], 5'd0});
                    end else begin
                        chk(mem_addr == fill_base + 32'(rd_beat * 4), "R4 fetch beat order", mem_addr, fill_base + 32'(rd_beat * 4));
                    end
                    mem_rdata = mem_rd(mem_addr);
                    rd_beat = (rd_beat + 1) % 8;
                end
                mem_ack = 1;
            end
        end
    end

    task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int stall);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; stall = 0;
        #1;
        while (cpu_wait && stall < 5000) begin
            @(negedge clk); #1; stall++;
        end
        rd = cpu_rdata;
        if (we) begin
            ref_mem[{a[31:2], 2'b00}] = d;
            exp_q.push_back({a[31:2], 2'b00, d});
            wr_issued++;
        end
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            quiet = mem_req ? 0 : quiet + 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int st;
        void'($urandom(32'd1234));
        rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(cpu_wait == 0, "R2 wait low in reset", cpu_wait, 0);
        chk(mem_req == 0, "R2 no memory request in reset", mem_req, 0);
        @(negedge clk); rst_n = 1;

        // R2/R4: first load misses and returns memory contents
        cpu_op(0, 32'h0000_0024, 0, rd, st);
        chk(st > 0, "R2 first load misses", st, 1);
        chk(rd == def_word(32'h24), "R4 fetched word", rd, def_word(32'h24));
        // R3: same line, other word, no stall
        cpu_op(0, 32'h0000_0028, 0, rd, st);
        chk(st == 0, "R3 hit without wait", st, 0);
        chk(rd == def_word(32'h28), "R3 hit data", rd, def_word(32'h28));
        // R1: same line bits, other tag evicts
        cpu_op(0, 32'h0000_0424, 0, rd, st);
        chk(st > 0, "R1 other tag misses", st, 1);
        chk(rd == def_word(32'h424), "R1 other tag data", rd, def_word(32'h424));
        cpu_op(0, 32'h0000_0024, 0, rd, st);
        chk(st > 0, "R1 evicted line misses", st, 1);
        // R5: store hit completes at once and updates the line
        cpu_op(1, 32'h0000_002C, 32'hCAFE_0001, rd, st);
        chk(st == 0, "R5 store no wait", st, 0);
        cpu_op(0, 32'h0000_002C, 0, rd, st);
        chk(st == 0, "R5 store hit keeps line resident", st, 0);
        chk(rd == 32'hCAFE_0001, "R5 store hit updates line", rd, 32'hCAFE_0001);
        // R6: store miss does not allocate
        cpu_op(1, 32'h0000_00E0, 32'hBEEF_0007, rd, st);
        chk(st == 0, "R6 store miss no wait", st, 0);
        cpu_op(0, 32'h0000_00E0, 0, rd, st);
        chk(st > 0, "R6 line not allocated on store miss", st, 1);
        chk(rd == 32'hBEEF_0007, "R9 load sees queued store", rd, 32'hBEEF_0007);

        // R7: four stores fit, the fifth waits
        wait_idle();
        mem_stall = 1;
        for (int i = 0; i < 4; i++) begin
            cpu_op(1, 32'h0000_0300 + 32'(i * 4), 32'h7700_0000 + 32'(i), rd, st);
            chk(st == 0, "R7 store accepted while queue not full", st, 0);
        end
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 32'h0000_0310; cpu_wdata = 32'h7700_0004;
        #1;
        chk(cpu_wait == 1, "R7 fifth store waits", cpu_wait, 1);
        repeat (3) @(negedge clk);
        #1;
        chk(cpu_wait == 1, "R7 still waiting while memory stalls", cpu_wait, 1);
        mem_stall = 0;
        while (cpu_wait) begin @(negedge clk); #1; end
        ref_mem[32'h0000_0310] = 32'h7700_0004;
        exp_q.push_back({32'h0000_0310, 32'h7700_0004});
        wr_issued++;
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;

        // Random traffic, checked against the reference image (R9)
        for (int k = 0; k < 500; k++) begin
            logic [31:0] a, d;
            bit w;
            w = ($urandom % 3) == 0;
            a = ((32'($urandom % 3)) << 10) | ((32'($urandom % 4)) << 5) | ((32'($urandom % 8)) << 2);
            d = $urandom;
            if (w) begin
                cpu_op(1, a, d, rd, st);
            end else begin
                logic [31:0] e;
                e = ref_rd(a);
                cpu_op(0, a, 0, rd, st);
                chk(rd == e, "R9 load returns latest value", rd, e);
            end
        end

        // R5: everything stored has reached memory
        wait_idle();
        chk(wr_seen == wr_issued, "R5 one memory write per store", wr_seen, wr_issued);
        foreach (ref_mem[key]) begin
            chk(mem_rd(key) == ref_mem[key], "R5 memory image", mem_rd(key), ref_mem[key]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule